// File: doc/BRIEF.md
# In-Order Issue Scoreboard with Operand Protection

This block decides, cycle by cycle, whether the instruction at the head of an in-order issue stage may be sent to its functional unit. Four independent units sit behind it: integer add, integer multiply/divide, floating-point add/multiply and floating-point divide/square-root. Each holds a single operation for as long as it needs, which may be a few cycles or around sixty, so results come back out of order. No registers are renamed. Safety therefore rests entirely on the issue check.

For every busy unit the scoreboard keeps the destination register and both source registers of the operation it holds. A new instruction is held back in four cases: its unit is occupied, it reads a pending destination, it writes a pending destination, or it overwrites a register that an uncompleted operation still reads. The last rule means a trap handler entered for any unfinished operation still finds that operation's original inputs in the register file.

A unit reports completion with a one-cycle strobe. The unit's tracking is released at that clock edge.

Register tags are six bits wide. Bit 5 selects the register class, with 0 meaning integer and 1 meaning floating point. Bits 4:0 hold the register index. Unit codes are 0 for integer add, 1 for integer multiply/divide, 2 for floating-point add/multiply and 3 for floating-point divide/square-root.

Top module: `scb_top`

## Requirements
- R1: Reset clears all tracking. After reset, even if operations were in flight before it, a request to any unit is granted when it has no register conflict.
- R2: `issue_grant` is never high while `req_valid` is low. `stall` is high exactly when `req_valid` is high and `issue_grant` is low.
- R3: A request to a unit that holds an uncompleted operation is stalled.
- R4: A request is stalled when either of its source tags equals the destination tag of any busy unit (read-after-write).
- R5: A request is stalled when its destination tag equals the destination tag of any busy unit (write-after-write).
- R6: A request is stalled when its destination tag equals either source tag of any busy unit (source protection).
- R7: A completion strobe frees the unit's tracking at the clock edge where the strobe is sampled. During the strobe cycle a request blocked only by that unit still stalls. In the following cycle it is granted.
- R8: Tags compare on class and index together. An integer register and a floating-point register with the same index never conflict.
- R9: Operations on different units overlap. A request to an idle unit with no register conflict is granted while other units are busy.
- R10: A completion strobe for an idle unit has no effect. In particular, it does not cancel an operation issued to that unit in the same cycle.
- R11: A completion on one unit and an issue to another unit in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Decoded instruction present |
| req_unit | input | 2 | Target unit code (0..3) |
| req_src_a | input | 6 | First source tag {class, index} |
| req_src_b | input | 6 | Second source tag {class, index} |
| req_dst | input | 6 | Destination tag {class, index} |
| done_strobe | input | 4 | One bit per unit; high for one cycle when that unit completes |
| issue_grant | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction present but held |

## Verification
Two things can land in the same cycle: one unit's completion strobe and a new issue. In one case the issue goes to a different unit. In the other it goes to the unit whose strobe arrives while that unit is already idle. Directed cycles force both overlaps. The first, for example, retires one unit while a floating-point divide issues to another, and is judged by the grant in that cycle and by what the next request to each unit sees. A random phase packs tags into a few register indices and fires strobes freely. A bench reference model then predicts every grant and stall.

// File: rtl/scb_pkg.sv
package scb_pkg;
    localparam int IDX_W     = 5;
    localparam int TAG_W     = IDX_W + 1;
    localparam int NUM_UNITS = 4;
    localparam int UNIT_W    = $clog2(NUM_UNITS);

    typedef enum logic [UNIT_W-1:0] {
        UNIT_IADD = 2'd0,
        UNIT_IMD  = 2'd1,
        UNIT_FAM  = 2'd2,
        UNIT_FDS  = 2'd3
    } unit_e;

    typedef struct packed {
        logic             fp;
        logic [IDX_W-1:0] idx;
    } reg_tag_t;

    typedef struct packed {
        reg_tag_t src_a;
        reg_tag_t src_b;
        reg_tag_t dst;
    } op_regs_t;

    function automatic logic tag_eq(reg_tag_t x, reg_tag_t y);
        return (x.fp == y.fp) && (x.idx == y.idx);
    endfunction
endpackage

// File: rtl/scb_slot.sv
module scb_slot
    import scb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     alloc,
    input  logic     done,
    input  op_regs_t op_in,
    output logic     busy,
    output op_regs_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            held <= '0;
        end else if (alloc) begin
            busy <= 1'b1;
            held <= op_in;
        end else if (done) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/scb_hazard.sv
module scb_hazard
    import scb_pkg::*;
#(
    parameter int N_UNITS = NUM_UNITS,
    localparam int U_W    = $clog2(N_UNITS)
) (
    input  logic                        req_valid,
    input  logic [U_W-1:0]              req_unit,
    input  op_regs_t                    req_op,
    input  logic [N_UNITS-1:0]          busy,
    input  op_regs_t [N_UNITS-1:0]      held,
    output logic                        unit_hit,
    output logic                        raw_hit,
    output logic                        waw_hit,
    output logic                        war_hit,
    output logic                        grant
);
    always_comb begin
        unit_hit = 1'b0;
        raw_hit  = 1'b0;
        waw_hit  = 1'b0;
        war_hit  = 1'b0;
        for (int u = 0; u < N_UNITS; u++) begin
            if (busy[u]) begin
                if (req_unit == U_W'(u))
                    unit_hit = 1'b1;
                if (tag_eq(req_op.src_a, held[u].dst) || tag_eq(req_op.src_b, held[u].dst))
                    raw_hit = 1'b1;
                if (tag_eq(req_op.dst, held[u].dst))
                    waw_hit = 1'b1;
                if (tag_eq(req_op.dst, held[u].src_a) || tag_eq(req_op.dst, held[u].src_b))
                    war_hit = 1'b1;
            end
        end
        grant = req_valid && !unit_hit && !raw_hit && !waw_hit && !war_hit;
    end
endmodule

// File: rtl/scb_top.sv
module scb_top
    import scb_pkg::*;
#(
    parameter int N_UNITS = NUM_UNITS,
    parameter int T_W     = TAG_W,
    localparam int U_W    = $clog2(N_UNITS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [U_W-1:0]     req_unit,
    input  logic [T_W-1:0]     req_src_a,
    input  logic [T_W-1:0]     req_src_b,
    input  logic [T_W-1:0]     req_dst,
    input  logic [N_UNITS-1:0] done_strobe,
    output logic               issue_grant,
    output logic               stall
);
    op_regs_t                   req_op;
    logic [N_UNITS-1:0]         slot_busy;
    op_regs_t [N_UNITS-1:0]     slot_held;
    logic                       unit_hit, raw_hit, waw_hit, war_hit;

    assign req_op.src_a = reg_tag_t'(req_src_a);
    assign req_op.src_b = reg_tag_t'(req_src_b);
    assign req_op.dst   = reg_tag_t'(req_dst);

    scb_hazard #(.N_UNITS(N_UNITS)) u_haz (
        .req_valid (req_valid),
        .req_unit  (req_unit),
        .req_op    (req_op),
        .busy      (slot_busy),
        .held      (slot_held),
        .unit_hit  (unit_hit),
        .raw_hit   (raw_hit),
        .waw_hit   (waw_hit),
        .war_hit   (war_hit),
        .grant     (issue_grant)
    );

    for (genvar u = 0; u < N_UNITS; u++) begin : g_slot
        scb_slot u_slot (
            .clk   (clk),
            .rst   (rst),
            .alloc (issue_grant && (req_unit == U_W'(u))),
            .done  (done_strobe[u]),
            .op_in (req_op),
            .busy  (slot_busy[u]),
            .held  (slot_held[u])
        );
    end

    assign stall = req_valid && !issue_grant;
endmodule

// File: rtl/scb_checker.sv
module scb_checker
    import scb_pkg::*;
#(
    parameter int N_UNITS = NUM_UNITS,
    localparam int U_W    = $clog2(N_UNITS)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic [U_W-1:0]          req_unit,
    input logic [TAG_W-1:0]        req_src_a,
    input logic [TAG_W-1:0]        req_src_b,
    input logic [TAG_W-1:0]        req_dst,
    input logic [N_UNITS-1:0]      done_strobe,
    input logic                    issue_grant,
    input logic [N_UNITS-1:0]      slot_busy,
    input op_regs_t [N_UNITS-1:0]  slot_held
);
    assert_grant_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !issue_grant);

    assert_empty_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> slot_busy == '0);

    for (genvar u = 0; u < N_UNITS; u++) begin : g_chk
        assert_busy_unit_blocks_R3: assert property (@(posedge clk) disable iff (rst)
            (issue_grant && req_unit == U_W'(u)) |-> !slot_busy[u]);

        assert_issue_marks_busy_R9: assert property (@(posedge clk) disable iff (rst)
            (issue_grant && req_unit == U_W'(u)) |=> slot_busy[u]);

        assert_no_raw_R4: assert property (@(posedge clk) disable iff (rst)
            (issue_grant && slot_busy[u]) |->
            (req_src_a != slot_held[u].dst && req_src_b != slot_held[u].dst));

        assert_no_waw_R5: assert property (@(posedge clk) disable iff (rst)
            (issue_grant && slot_busy[u]) |-> (req_dst != slot_held[u].dst));

        assert_no_war_R6: assert property (@(posedge clk) disable iff (rst)
            (issue_grant && slot_busy[u]) |->
            (req_dst != slot_held[u].src_a && req_dst != slot_held[u].src_b));

        assert_done_frees_R7: assert property (@(posedge clk) disable iff (rst)
            (slot_busy[u] && done_strobe[u]) |=> !slot_busy[u]);

        assert_idle_done_ignored_R10: assert property (@(posedge clk) disable iff (rst)
            (!slot_busy[u] && done_strobe[u] && issue_grant && req_unit == U_W'(u)) |=> slot_busy[u]);
    end
endmodule

bind scb_top scb_checker #(.N_UNITS(N_UNITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_unit    (req_unit),
    .req_src_a   (req_src_a),
    .req_src_b   (req_src_b),
    .req_dst     (req_dst),
    .done_strobe (done_strobe),
    .issue_grant (issue_grant),
    .slot_busy   (slot_busy),
    .slot_held   (slot_held)
);

// File: tb/scb_top_tb.sv
module scb_top_tb;
    localparam int NU = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_unit = '0;
    logic [5:0] req_src_a = '0, req_src_b = '0, req_dst = '0;
    logic [NU-1:0] done_strobe = '0;
    logic       issue_grant, stall;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench reference state
    bit       m_busy [NU];
    bit [5:0] m_dst  [NU];
    bit [5:0] m_sa   [NU];
    bit [5:0] m_sb   [NU];

    always #10 clk = ~clk;

    scb_top u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_unit(req_unit),
        .req_src_a(req_src_a), .req_src_b(req_src_b), .req_dst(req_dst),
        .done_strobe(done_strobe), .issue_grant(issue_grant), .stall(stall)
    );

    function automatic bit exp_grant(bit v, int unit, bit [5:0] a, bit [5:0] b, bit [5:0] d);
        if (!v) return 0;
        for (int u = 0; u < NU; u++) begin
            if (m_busy[u]) begin
                if (u == unit) return 0;
                if (a == m_dst[u] || b == m_dst[u]) return 0;
                if (d == m_dst[u]) return 0;
                if (d == m_sa[u] || d == m_sb[u]) return 0;
            end
        end
        return 1;
    endfunction

    function automatic bit [5:0] itag(int i); return {1'b0, 5'(i)}; endfunction
    function automatic bit [5:0] ftag(int i); return {1'b1, 5'(i)}; endfunction

    task automatic check(string req, bit act, bit exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, sample late, update model for the coming edge
    task automatic cyc(string req, bit v, int unit, bit [5:0] a, bit [5:0] b, bit [5:0] d,
                       bit [NU-1:0] dn, int want);
        bit eg;
        @(negedge clk);
        req_valid = v; req_unit = 2'(unit); req_src_a = a; req_src_b = b; req_dst = d;
        done_strobe = dn;
        #8;
        eg = exp_grant(v, unit, a, b, d);
        if (want >= 0) check(req, eg, bit'(want), "model vs directed expectation");
        check(req, issue_grant, eg, "issue_grant");
        check("R2", stall, v && !eg, "stall");
        for (int u = 0; u < NU; u++) begin
            if (eg && u == unit) begin
                m_busy[u] = 1; m_dst[u] = d; m_sa[u] = a; m_sb[u] = b;
            end else if (dn[u]) begin
                m_busy[u] = 0;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 0; done_strobe = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int u = 0; u < NU; u++) m_busy[u] = 0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        cyc("R2",  0, 0, itag(1), itag(2), itag(3), '0, 0);
        cyc("R1",  1, 1, itag(5), itag(6), itag(4), '0, 1);
        cyc("R3",  1, 1, itag(10), itag(11), itag(9), '0, 0);
        cyc("R9",  1, 3, ftag(2), ftag(3), ftag(1), '0, 1);
        cyc("R6",  1, 2, ftag(7), ftag(8), ftag(2), '0, 0);
        cyc("R4",  1, 0, itag(4), itag(13), itag(12), '0, 0);
        cyc("R5",  1, 0, itag(12), itag(13), itag(4), '0, 0);
        cyc("R8",  1, 0, itag(2), itag(3), itag(1), '0, 1);
        cyc("R7",  1, 2, ftag(7), ftag(8), ftag(2), 4'b1000, 0);
        cyc("R7",  1, 2, ftag(7), ftag(8), ftag(2), '0, 1);
        cyc("R11", 1, 3, ftag(10), ftag(11), ftag(9), 4'b0001, 1);
        cyc("R11", 1, 0, itag(21), itag(22), itag(20), '0, 1);
        cyc("R10", 0, 0, itag(0), itag(0), itag(0), 4'b0001, -1);
        cyc("R10", 1, 0, itag(24), itag(25), itag(23), 4'b0001, 1);
        cyc("R10", 1, 0, itag(27), itag(28), itag(26), '0, 0);
        // reset with units busy: tracking must be gone
        do_reset();
        cyc("R1",  1, 1, ftag(2), itag(5), itag(4), '0, 1);
        cyc("R1",  1, 3, ftag(9), itag(6), ftag(1), '0, 1);

        // random phase: small index pool for frequent conflicts
        for (int i = 0; i < 4000; i++) begin
            bit [5:0] a, b, d;
            a = {1'($urandom_range(1)), 5'($urandom_range(3))};
            b = {1'($urandom_range(1)), 5'($urandom_range(3))};
            d = {1'($urandom_range(1)), 5'($urandom_range(3))};
            cyc("R3/R4/R5/R6", ($urandom_range(3) != 0), $urandom_range(3), a, b, d,
                4'($urandom_range(15) & $urandom_range(15)), -1);
        end
        report();
    end
endmodule